// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins arranged as two banks of eight. Software reaches it through a byte-wide register port with a single-cycle write strobe and combinational read data. Each pin has two per-pin registers. The output-control register holds direction, driver type, pull enable, pull selection and the driven level. The input-control register returns the synchronized pin level and holds a two-bit interrupt edge selector.

Incoming pin levels pass through a two-flop synchronizer. Each synchronized level is then compared with its value one clock earlier to find edges. An edge that matches the pin's selector sets the pin's bit in its bank's pending register. Software clears pending bits by writing ones. Each bank also has a mask register, in which a set bit blocks that pin from the interrupt line. A single interrupt output is high while any pending bit is set whose mask bit is clear.

The pad analog behaviour is outside this block. It produces only the resolved pad output level, the output enable and the pull controls.

Top module: `gpio_edge_bank`

Register map (6-bit byte address): output-control of pin n at 0x00+n, input-control of pin n at 0x10+n, pending of bank 0/1 at 0x20/0x21, mask of bank 0/1 at 0x22/0x23. Pin n is in bank n/8 and uses bit n mod 8 of the bank registers.

## Requirements
- R1: After a synchronous active-low reset, every output-control and input-control field is zero (input, push-pull, pull off, interrupts off), both pending registers are 0x00, both mask registers are 0xFF and irq_o is low.
- R2: Output-control of pin n sits at address n. Bits [5:0] are writable and read back, and bits [7:6] read as zero. Bit 5 is direction (1 = output), bit 4 is open-drain (1), bit 3 is pull enable and bits [2:1] are the pull select, with bit 0 as the output level.
- R3: pad_out_o[n] equals output-control bit 0. pad_oe_o[n] is high when bit 5 is set and either bit 4 is clear or bit 0 is clear, so an open-drain pin never drives a high level.
- R4: pull_en_o[n] equals output-control bit 3. The pull select decodes as 0 strong down, 1 strong up, 2 weak down and 3 weak up: pull_up_o[n] is bit 1 and pull_weak_o[n] is bit 2.
- R5: Input-control of pin n sits at address 0x10+n. Bit 0 reads the synchronized pin level, which follows a pin change after two clock edges. Bits [2:1] are the writable edge selector, and bits [7:3] read zero.
- R6: Edge selector 0 sets no pending bit, 1 sets on a falling edge, 2 on a rising edge and 3 on both edges. A pending bit is set on the third clock edge after the pin change.
- R7: Writing the pending register of a bank clears every bit written as 1 and leaves bits written as 0 unchanged.
- R8: If an edge is detected on a pin in the same cycle that its pending bit is written with 1, the bit stays set.
- R9: irq_o is the OR over both banks of pending AND NOT mask. A pending bit still sets while its pin is masked, so clearing the mask bit later raises irq_o.
- R10: Addresses 0x24 to 0x3F read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 6 | Register byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| pin_i | input | 16 | Asynchronous pin levels |
| pad_out_o | output | 16 | Level driven on each pad |
| pad_oe_o | output | 16 | Resolved pad output enable |
| pull_en_o | output | 16 | Pull resistor enable |
| pull_up_o | output | 16 | Pull direction, 1 = up |
| pull_weak_o | output | 16 | Pull strength, 1 = weak |
| irq_o | output | 1 | Interrupt, any unmasked pending bit |

## Verification
The bench drives a write-one-to-clear into a pending bit in exactly the cycle its new edge is detected. A design that lets the clear win would lose that interrupt. It sets pending bits while the pin is masked and then unmasks. A design that gates pending capture with the mask would keep irq_o low. It samples the input-control level one and two cycles after a pin change, and checks each edge selector in both directions. These checks catch a wrong synchronizer depth or swapped falling/rising codes. Open-drain pins driving high are checked to have the enable dropped, and writes of zero bits and writes to unmapped addresses are checked to leave state alone.

// File: rtl/gpio_bank_pkg.sv
// Package: shared geometry and register-map constants for the GPIO controller.
// Assumes a byte-wide register port and a flat address space in which the
// per-pin registers come first, followed by the per-bank registers.
package gpio_bank_pkg;
    parameter int NUM_BANKS     = 2;
    parameter int PINS_PER_BANK = 8;
    parameter int ADDR_W        = 6;
    parameter int DATA_W        = 8;

    localparam int NUM_PINS  = NUM_BANKS * PINS_PER_BANK;
    localparam int OCTL_BASE = 0;
    localparam int ICTL_BASE = NUM_PINS;
    localparam int PEND_BASE = 2 * NUM_PINS;
    localparam int MASK_BASE = 2 * NUM_PINS + NUM_BANKS;

    // Output-control field view (bits [5:0] of the register)
    typedef struct packed {
        logic       dir_out;
        logic       open_drain;
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       level;
    } octl_t;

    // Edge selector codes
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Two-flop synchronizer for a vector of asynchronous pin inputs.
// Assumes each bit is independent; no bus coherency is provided.
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Purpose: capture the raw inputs and resample them once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

    // The synchronized output is always the first stage one clock late (R5)
    p_sync_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stage2_q == $past(stage1_q));
endmodule

// File: rtl/gpio_pin_ctl.sv
// Module: gpio_pin_ctl
// Control state for one pin: the output-control fields, the edge selector,
// the previous synchronized level and the edge detector. It also resolves
// the pad enable and the pull controls.
// Assumes lvl_i is already synchronized to clk.
module gpio_pin_ctl
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        octl_wr_i,
    input  logic        ictl_wr_i,
    input  logic [7:0]  wdata_i,
    input  logic        lvl_i,
    output logic [5:0]  octl_o,
    output logic [1:0]  esel_o,
    output logic        edge_o,
    output logic        pad_out_o,
    output logic        pad_oe_o,
    output logic        pull_en_o,
    output logic        pull_up_o,
    output logic        pull_weak_o
);
    octl_t       octl_q;
    logic [1:0]  esel_q;
    logic        prev_q;
    logic        rise, fall;

    // Purpose: register writes to the output-control and edge selector fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            octl_q <= '0;
            esel_q <= EDGE_OFF;
        end else begin
            if (octl_wr_i) octl_q <= octl_t'(wdata_i[5:0]);
            if (ictl_wr_i) esel_q <= wdata_i[2:1];
        end
    end

    // Purpose: keep the level of the previous cycle for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    // Purpose: qualify raw transitions with the selected edge mode.
    always_comb begin
        rise   = lvl_i & ~prev_q;
        fall   = ~lvl_i & prev_q;
        edge_o = (esel_q[1] & rise) | (esel_q[0] & fall);
    end

    assign octl_o      = octl_q;
    assign esel_o      = esel_q;
    assign pad_out_o   = octl_q.level;
    assign pad_oe_o    = octl_q.dir_out & (~octl_q.open_drain | ~octl_q.level);
    assign pull_en_o   = octl_q.pull_en;
    assign pull_up_o   = octl_q.pull_sel[0];
    assign pull_weak_o = octl_q.pull_sel[1];

    // A disabled selector never reports an edge (R6)
    p_off_no_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (esel_q == EDGE_OFF) |-> !edge_o);
endmodule

// File: rtl/gpio_irq_bank.sv
// Module: gpio_irq_bank
// Pending and mask registers for one bank. Edges set pending bits, and a
// write of ones clears them; an edge takes priority over a clear in the
// same cycle. Produces the bank's share of the interrupt.
module gpio_irq_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_wr_i,
    input  logic             mask_wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] edge_i,
    output logic [WIDTH-1:0] pend_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             irq_o
);
    logic [WIDTH-1:0] pend_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] clr;

    assign clr = pend_wr_i ? wdata_i : '0;

    // Purpose: update pending bits, with a new edge winning over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | edge_i;
    end

    // Purpose: hold the mask, fully masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '1;
        else if (mask_wr_i) mask_q <= wdata_i;
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
    assign irq_o  = |(pend_q & ~mask_q);

    // Without an edge or a clear write, pending is unchanged (R7)
    p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i == '0 && !pend_wr_i) |=> $stable(pend_q));
    // Every detected edge is captured, whatever the bus does (R8)
    p_edge_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i != '0) |=> ((pend_q & $past(edge_i)) == $past(edge_i)));
    // Cleared bits with no concurrent edge end up zero (R7)
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr_i |=> ((pend_q & $past(wdata_i & ~edge_i)) == '0));
endmodule

// File: rtl/gpio_edge_bank.sv
// Module: gpio_edge_bank (top)
// Banked GPIO controller: register decode, per-pin control, input
// synchronizer and per-bank interrupt registers.
// Assumes one bus write per cycle and combinational read data.
module gpio_edge_bank
    import gpio_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pull_en_o,
    output logic [NUM_PINS-1:0] pull_up_o,
    output logic [NUM_PINS-1:0] pull_weak_o,
    output logic                irq_o
);
    logic [NUM_PINS-1:0]      lvl;
    logic [NUM_PINS-1:0]      edge_v;
    logic [NUM_PINS-1:0]      octl_wr, ictl_wr;
    logic [5:0]               octl [NUM_PINS];
    logic [1:0]               esel [NUM_PINS];
    logic [NUM_BANKS-1:0]     pend_wr, mask_wr, bank_irq;
    logic [PINS_PER_BANK-1:0] pend [NUM_BANKS];
    logic [PINS_PER_BANK-1:0] mask [NUM_BANKS];

    gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (lvl)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
            assign octl_wr[gp] = bus_wr_i && (bus_addr_i == ADDR_W'(OCTL_BASE + gp));
            assign ictl_wr[gp] = bus_wr_i && (bus_addr_i == ADDR_W'(ICTL_BASE + gp));
            gpio_pin_ctl u_pin (
                .clk         (clk),
                .rst_n       (rst_n),
                .octl_wr_i   (octl_wr[gp]),
                .ictl_wr_i   (ictl_wr[gp]),
                .wdata_i     (bus_wdata_i),
                .lvl_i       (lvl[gp]),
                .octl_o      (octl[gp]),
                .esel_o      (esel[gp]),
                .edge_o      (edge_v[gp]),
                .pad_out_o   (pad_out_o[gp]),
                .pad_oe_o    (pad_oe_o[gp]),
                .pull_en_o   (pull_en_o[gp]),
                .pull_up_o   (pull_up_o[gp]),
                .pull_weak_o (pull_weak_o[gp])
            );
        end
    endgenerate

    genvar gb;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            assign pend_wr[gb] = bus_wr_i && (bus_addr_i == ADDR_W'(PEND_BASE + gb));
            assign mask_wr[gb] = bus_wr_i && (bus_addr_i == ADDR_W'(MASK_BASE + gb));
            gpio_irq_bank #(.WIDTH(PINS_PER_BANK)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .pend_wr_i (pend_wr[gb]),
                .mask_wr_i (mask_wr[gb]),
                .wdata_i   (bus_wdata_i[PINS_PER_BANK-1:0]),
                .edge_i    (edge_v[gb*PINS_PER_BANK +: PINS_PER_BANK]),
                .pend_o    (pend[gb]),
                .mask_o    (mask[gb]),
                .irq_o     (bank_irq[gb])
            );
        end
    endgenerate

    assign irq_o = |bank_irq;

    // Purpose: select the read data for the addressed register, zero if unmapped.
    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_addr_i == ADDR_W'(OCTL_BASE + i))
                bus_rdata_o = DATA_W'({octl[i]});
            if (bus_addr_i == ADDR_W'(ICTL_BASE + i))
                bus_rdata_o = DATA_W'({esel[i], lvl[i]});
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr_i == ADDR_W'(PEND_BASE + b))
                bus_rdata_o = DATA_W'(pend[b]);
            if (bus_addr_i == ADDR_W'(MASK_BASE + b))
                bus_rdata_o = DATA_W'(mask[b]);
        end
    end

    // With every pin masked, the interrupt stays low (R9)
    p_all_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[0] == '1 && mask[1] == '1) |-> !irq_o);
    // At most one register is written per bus cycle (R10)
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({octl_wr, ictl_wr, pend_wr, mask_wr}) <= 1);
endmodule

// File: tb/gpio_edge_bank_tb_top.sv
module gpio_edge_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] pin = '0;
    logic [15:0] pad_out, pad_oe, pull_en, pull_up, pull_weak;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Bench-side model of the programmed state
    logic [5:0] m_octl [16];
    logic [1:0] m_sel  [16];
    logic [7:0] m_pend [2];
    logic [7:0] m_mask [2];

    always #5 clk = ~clk;

    gpio_edge_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .pin_i(pin),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pull_en_o(pull_en),
        .pull_up_o(pull_up), .pull_weak_o(pull_weak), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic edge_hit(input logic [1:0] sel, input logic old_v, input logic new_v);
        return (sel[1] && !old_v && new_v) || (sel[0] && old_v && !new_v);
    endfunction

    function automatic logic exp_irq();
        return |(m_pend[0] & ~m_mask[0]) || |(m_pend[1] & ~m_mask[1]);
    endfunction

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_octl(input int p, input logic [7:0] d);
        wr(6'(p), d); m_octl[p] = d[5:0];
    endtask
    task automatic set_sel(input int p, input logic [1:0] s);
        wr(6'(16 + p), {5'b0, s, 1'b1}); m_sel[p] = s;
    endtask
    task automatic clr_pend(input int b, input logic [7:0] d);
        wr(6'(32 + b), d); m_pend[b] = m_pend[b] & ~d;
    endtask
    task automatic set_mask(input int b, input logic [7:0] d);
        wr(6'(34 + b), d); m_mask[b] = d;
    endtask

    task automatic drive_pins(input logic [15:0] nv);
        @(negedge clk);
        for (int i = 0; i < 16; i++)
            if (edge_hit(m_sel[i], pin[i], nv[i])) m_pend[i/8][i%8] = 1'b1;
        pin = nv;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        logic [7:0] d;
        logic [15:0] e_oe, e_out, e_pe, e_up, e_wk;
        for (int b = 0; b < 2; b++) begin
            rd(6'(32 + b), d); check({"R6/R7 pending ", tag}, d, m_pend[b]);
            rd(6'(34 + b), d); check({"R9 mask ", tag}, d, m_mask[b]);
        end
        for (int i = 0; i < 16; i++) begin
            e_out[i] = m_octl[i][0];
            e_oe[i]  = m_octl[i][5] && (!m_octl[i][4] || !m_octl[i][0]);
            e_pe[i]  = m_octl[i][3];
            e_up[i]  = m_octl[i][1];
            e_wk[i]  = m_octl[i][2];
        end
        check({"R3 pad_out ", tag}, pad_out, e_out);
        check({"R3 pad_oe ", tag}, pad_oe, e_oe);
        check({"R4 pull ", tag}, {pull_en, pull_up, pull_weak}, {e_pe, e_up, e_wk});
        check({"R9 irq ", tag}, irq, exp_irq());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int unsigned r;
        for (int i = 0; i < 16; i++) begin m_octl[i] = '0; m_sel[i] = '0; end
        m_pend[0] = '0; m_pend[1] = '0; m_mask[0] = '1; m_mask[1] = '1;
        r = $urandom(32'h1357);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every register and the interrupt
        for (int i = 0; i < 32; i++) begin
            rd(6'(i), d); check("R1 per-pin reset", d, 8'h00);
        end
        check_state("R1 reset");

        // R2: full write readback, upper bits read zero
        set_octl(3, 8'hFF);
        rd(6'd3, d); check("R2 octl readback", d, 8'h3F);
        set_octl(11, 8'h2A);
        rd(6'd11, d); check("R2 octl pin 11", d, 8'h2A);
        rd(6'd3, d); check("R2 neighbour untouched", d, 8'h3F);
        // R3: open-drain high level releases the pad
        check_state("R3 od high");
        set_octl(3, 8'h30);
        check("R3 od low drives", pad_oe[3], 1'b1);

        // R5: readback latency of two edges
        @(negedge clk);
        pin[5] = 1'b1;
        @(negedge clk); rd(6'd21, d); check("R5 level after one edge", d[0], 1'b0);
        @(negedge clk); rd(6'd21, d); check("R5 level after two edges", d[0], 1'b1);
        set_sel(5, 2'd3);
        rd(6'd21, d); check("R5 ictl readback", d, 8'h07);
        pin[5] = 1'b0; m_sel[5] = 2'd0; set_sel(5, 2'd0);
        repeat (4) @(negedge clk);

        // R6: each selector code in both directions on pin 9
        for (int s = 0; s < 4; s++) begin
            set_sel(9, 2'(s));
            drive_pins(pin | 16'h0200);
            rd(6'd33, d); check("R6 rising", d[1], 1'(s >= 2));
            clr_pend(1, 8'hFF);
            drive_pins(pin & ~16'h0200);
            rd(6'd33, d); check("R6 falling", d[1], 1'(s == 1 || s == 3));
            clr_pend(1, 8'hFF);
        end

        // R7: zeros leave bits alone, ones clear
        set_sel(0, 2'd2); set_sel(1, 2'd2);
        drive_pins(pin | 16'h0003);
        clr_pend(0, 8'h01);
        check_state("R7 partial clear");
        rd(6'd32, d); check("R7 bit1 kept", d, 8'h02);

        // R9: capture while masked, irq on unmask
        check("R9 masked irq low", irq, 1'b0);
        set_mask(0, 8'hFD);
        check("R9 unmask raises irq", irq, 1'b1);
        clr_pend(0, 8'h02);
        check("R9 irq falls on clear", irq, 1'b0);

        // R8: edge detected in the same cycle as its clear
        set_sel(4, 2'd2);
        @(negedge clk);
        pin[4] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'd32; bus_wdata = 8'h10;
        @(negedge clk);
        bus_wr = 1'b0;
        m_pend[0][4] = 1'b1;
        rd(6'd32, d); check("R8 edge beats clear", d[4], 1'b1);
        clr_pend(0, 8'h10);
        rd(6'd32, d); check("R8 clear afterwards", d[4], 1'b0);

        // R10: unmapped addresses
        wr(6'd36, 8'hFF); wr(6'd63, 8'hFF);
        rd(6'd36, d); check("R10 unmapped reads zero", d, 8'h00);
        rd(6'd63, d); check("R10 top address reads zero", d, 8'h00);
        check_state("R10 no side effect");

        // Random mix of writes and pin activity
        for (int it = 0; it < 120; it++) begin
            r = $urandom();
            case (r % 5)
                0: set_octl(int'($urandom() % 16), 8'($urandom()));
                1: set_sel(int'($urandom() % 16), 2'($urandom()));
                2: drive_pins(16'($urandom()));
                3: clr_pend(int'($urandom() % 2), 8'($urandom()));
                default: set_mask(int'($urandom() % 2), 8'($urandom()));
            endcase
            check_state("R6 random");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule